// File: doc/BRIEF.md
# Floating-Point Sign Operation Unit

This unit carries out the three sign-only floating-point operations on one operand: a plain register copy, absolute value and negation. It handles either a binary32 value, held in the low half of a 64-bit operand, or a full binary64 value. Absolute value clears the sign bit of the chosen format. Negation flips that sign bit. Neither touches the exponent or the fraction, so the unit has no rounding and raises no exceptions.

A mode input can turn on default-NaN handling. While it is on, any absolute-value or negation result that is a NaN is replaced by the format's canonical quiet NaN. A plain copy never gets this treatment, so a copy keeps NaN payloads exactly. The operation is picked by a 4-bit primary code and a 2-bit secondary code. A code pair the unit does not know raises an illegal-operation flag, and the held result is left as it was. Results are registered and appear one clock after the request.

Top module: `fpsign_unit`

## Requirements
- R1: After a synchronous active-low reset, res_vld, res_illegal and res_data are all zero.
- R2: A request accepted with req_vld high produces res_vld high, with its result on res_data, on the clock edge that follows the accepting edge. res_illegal is low on that cycle.
- R3: Code pair (primary 0, secondary 1) is a copy. With req_dbl=1 all 64 bits are copied. With req_dbl=0 bits 31:0 are copied and bits 63:32 of the result are zero. NaN values pass unchanged whatever the default-NaN mode.
- R4: Code pair (primary 0, secondary 3) is absolute value. It clears bit 63 (binary64) or bit 31 (binary32) and keeps all other bits of the selected format.
- R5: Code pair (primary 1, secondary 1) is negation. It inverts bit 63 (binary64) or bit 31 (binary32) and keeps all other bits of the selected format.
- R6: When req_dnan=1, an absolute-value or negation result that is a NaN becomes 0x7FF8000000000000 (binary64) or 0x000000007FC00000 (binary32). A NaN is a value whose exponent field is all ones and whose fraction is nonzero. Infinities and all other values are not replaced.
- R7: When req_dnan=0, absolute-value and negation results that are NaNs keep their payload. Only the sign bit changes.
- R8: Any other code pair, accepted with req_vld high, sets res_illegal high and res_vld low one cycle later, and leaves res_data unchanged.
- R9: A cycle with req_vld low gives res_vld and res_illegal low on the next cycle, and res_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Request strobe |
| req_pri | input | 4 | Primary operation code |
| req_sec | input | 2 | Secondary operation code |
| req_dbl | input | 1 | 1 = binary64, 0 = binary32 in bits 31:0 |
| req_dnan | input | 1 | Default-NaN mode enable |
| req_data | input | 64 | Operand |
| res_vld | output | 1 | Result valid |
| res_illegal | output | 1 | Unknown code pair was requested |
| res_data | output | 64 | Result |

## Verification
Every result (res_vld, res_illegal and res_data) is due exactly one clock after the edge that accepts the request, because the path has a single register stage. The bench drives each request on a falling edge and lets one rising edge pass. On the next falling edge it compares all three outputs against a queued prediction from its own model. Idle and illegal cycles use the same timing, so checks that res_data holds are made in the cycle right after the stimulus.

// File: rtl/fpsign_pkg.sv
// Package: shared widths, format constants and operation type for the
// sign operation unit. Assumes IEEE 754 binary32/binary64 layouts.
package fpsign_pkg;

    parameter int DATA_W = 64;   // operand / result width
    parameter int SGL_W  = 32;   // binary32 width
    parameter int SGL_EW = 8;    // binary32 exponent width
    parameter int DBL_EW = 11;   // binary64 exponent width
    parameter int PRI_W  = 4;    // primary code width
    parameter int SEC_W  = 2;    // secondary code width

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_ABS  = 2'd1,
        OP_NEG  = 2'd2,
        OP_NONE = 2'd3
    } sign_op_e;

endpackage

// File: rtl/fpsign_decode.sv
// Module: fpsign_decode
// Maps the primary/secondary code pair onto a sign operation and flags
// pairs that are not recognised. Purely combinational.
module fpsign_decode
    import fpsign_pkg::*;
(
    input  logic [PRI_W-1:0] pri,
    input  logic [SEC_W-1:0] sec,
    output sign_op_e         op,
    output logic             legal
);

    // Translate the code pair; anything unmatched becomes OP_NONE.
    always_comb begin
        op = OP_NONE;
        if (pri == PRI_W'(0) && sec == SEC_W'(1)) op = OP_COPY;
        if (pri == PRI_W'(0) && sec == SEC_W'(3)) op = OP_ABS;
        if (pri == PRI_W'(1) && sec == SEC_W'(1)) op = OP_NEG;
    end

    // A pair is legal when it decoded to a real operation.
    always_comb legal = (op != OP_NONE);

endmodule

// File: rtl/fpsign_lane.sv
// Module: fpsign_lane
// One format lane: applies copy/abs/neg to a W-bit value and, when the
// default-NaN mode is on, swaps NaN results of abs/neg for the canonical
// quiet NaN. Assumes a sign/exponent/fraction layout with EXP_W exponent bits.
module fpsign_lane
    import fpsign_pkg::*;
#(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  sign_op_e       op,
    input  logic           dnan,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   res
);

    localparam int FRAC_W = W - 1 - EXP_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         raw_nan;

    // Sign-bit manipulation for the selected operation.
    always_comb begin
        case (op)
            OP_ABS:  raw = {1'b0, opnd[W-2:0]};
            OP_NEG:  raw = {~opnd[W-1], opnd[W-2:0]};
            default: raw = opnd;
        endcase
    end

    // NaN: exponent all ones and fraction nonzero.
    always_comb raw_nan = (&raw[W-2:FRAC_W]) && (|raw[FRAC_W-1:0]);

    // Default-NaN replacement, only for abs and neg.
    always_comb begin
        if (dnan && raw_nan && (op == OP_ABS || op == OP_NEG))
            res = CANON_NAN;
        else
            res = raw;
    end

endmodule

// File: rtl/fpsign_unit.sv
// Module: fpsign_unit (top)
// Sign operation unit: decodes the code pair, runs both format lanes in
// parallel, selects by size and registers the result. One cycle latency.
// Assumes a binary32 operand sits in bits 31:0 of req_data.
module fpsign_unit
    import fpsign_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [3:0]        req_pri,
    input  logic [1:0]        req_sec,
    input  logic              req_dbl,
    input  logic              req_dnan,
    input  logic [63:0]       req_data,
    output logic              res_vld,
    output logic              res_illegal,
    output logic [63:0]       res_data
);

    localparam int PAD_W = DATA_W - SGL_W;

    sign_op_e            op;
    logic                legal;
    logic [SGL_W-1:0]    sgl_res;
    logic [DATA_W-1:0]   dbl_res;
    logic [DATA_W-1:0]   nxt_data;

    fpsign_decode u_dec (
        .pri   (req_pri),
        .sec   (req_sec),
        .op    (op),
        .legal (legal)
    );

    fpsign_lane #(.W(SGL_W), .EXP_W(SGL_EW)) u_sgl (
        .op   (op),
        .dnan (req_dnan),
        .opnd (req_data[SGL_W-1:0]),
        .res  (sgl_res)
    );

    fpsign_lane #(.W(DATA_W), .EXP_W(DBL_EW)) u_dbl (
        .op   (op),
        .dnan (req_dnan),
        .opnd (req_data),
        .res  (dbl_res)
    );

    // Pick the lane for the requested size; binary32 is zero-extended.
    always_comb nxt_data = req_dbl ? dbl_res : {{PAD_W{1'b0}}, sgl_res};

    // Output register: result and flags, data only on legal requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld     <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
        end else begin
            res_vld     <= req_vld && legal;
            res_illegal <= req_vld && !legal;
            if (req_vld && legal) res_data <= nxt_data;
        end
    end

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && legal) |=> (res_vld && !res_illegal));

    a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !legal) |=> (res_illegal && !res_vld && $stable(res_data)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_vld) |=> (!res_vld && !res_illegal && $stable(res_data)));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && legal && !req_dbl) |=> (res_data[63:32] == 32'h0));

    a_r3_copy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && op == OP_COPY && req_dbl) |=> (res_data == $past(req_data)));

endmodule

// File: tb/test_fpsign_unit.sv
`timescale 1ns/1ps
module test_fpsign_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [3:0]  req_pri = '0;
    logic [1:0]  req_sec = '0;
    logic        req_dbl = 1'b0;
    logic        req_dnan = 1'b0;
    logic [63:0] req_data = '0;
    logic        res_vld;
    logic        res_illegal;
    logic [63:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          vld;
        bit          ill;
        logic [63:0] data;
    } exp_t;
    exp_t exp_q[$];
    logic [63:0] model_data = '0;

    always #10 clk = ~clk;   // 50 MHz

    fpsign_unit i_fpsign_unit (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pri(req_pri),
        .req_sec(req_sec), .req_dbl(req_dbl), .req_dnan(req_dnan),
        .req_data(req_data), .res_vld(res_vld), .res_illegal(res_illegal),
        .res_data(res_data)
    );

    // Behavioural reference for one request.
    function automatic exp_t predict(bit v, bit dbl, bit dn, logic [3:0] a,
                                     logic [1:0] b, logic [63:0] d);
        exp_t e;
        int kind;          // 0 copy, 1 abs, 2 neg, -1 bad
        logic [63:0] r;
        bit nan;
        kind = -1;
        if (a == 0 && b == 1) kind = 0;
        else if (a == 0 && b == 3) kind = 1;
        else if (a == 1 && b == 1) kind = 2;
        e.data = model_data;
        e.vld = 0;
        e.ill = 0;
        if (!v) return e;
        if (kind < 0) begin e.ill = 1; return e; end
        if (dbl) begin
            r = d;
            if (kind == 1) r[63] = 1'b0;
            if (kind == 2) r[63] = ~r[63];
            nan = (r[62:52] == 11'h7FF) && (r[51:0] != 0);
            if (dn && kind != 0 && nan) r = 64'h7FF8000000000000;
        end else begin
            r = {32'h0, d[31:0]};
            if (kind == 1) r[31] = 1'b0;
            if (kind == 2) r[31] = ~r[31];
            nan = (r[30:23] == 8'hFF) && (r[22:0] != 0);
            if (dn && kind != 0 && nan) r = 64'h7FC00000;
        end
        e.vld = 1;
        e.data = r;
        return e;
    endfunction

    task automatic compare(string tag);
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (res_vld !== e.vld || res_illegal !== e.ill || res_data !== e.data) begin
            errors++;
            $display("FAIL %s: got vld=%0b ill=%0b data=%h, expected vld=%0b ill=%0b data=%h",
                     tag, res_vld, res_illegal, res_data, e.vld, e.ill, e.data);
        end
    endtask

    // Drive one request at a falling edge, check one cycle later.
    task automatic step(bit v, bit dbl, bit dn, logic [3:0] a, logic [1:0] b,
                        logic [63:0] d, string tag);
        exp_t e;
        req_vld = v; req_dbl = dbl; req_dnan = dn;
        req_pri = a; req_sec = b; req_data = d;
        e = predict(v, dbl, dn, a, b, d);
        exp_q.push_back(e);
        model_data = e.data;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        exp_q.push_back('{vld: 0, ill: 0, data: 64'h0});
        compare("R1 reset");
        rst_n = 1'b1;

        step(1, 1, 1, 0, 1, 64'h7FF0_0000_0000_0001, "R3 copy64 NaN dnan on");
        step(1, 0, 1, 0, 1, 64'hDEAD_BEEF_FFC1_2345, "R3 copy32 upper dropped");
        step(1, 1, 0, 0, 1, 64'hC00A_1234_5678_9ABC, "R2 R3 copy64");
        step(1, 1, 0, 0, 3, 64'hC00A_1234_5678_9ABC, "R4 abs64");
        step(1, 0, 0, 0, 3, 64'h1234_5678_BF80_0000, "R4 abs32");
        step(1, 1, 0, 1, 1, 64'h3FF0_0000_0000_0000, "R5 neg64");
        step(1, 0, 0, 1, 1, 64'h0000_0000_3F80_0000, "R5 neg32");
        step(1, 0, 1, 1, 1, 64'h0000_0000_0000_0000, "R5 neg32 zero");
        step(1, 1, 1, 0, 3, 64'hFFF4_0000_0000_00AB, "R6 abs64 NaN");
        step(1, 0, 1, 1, 1, 64'h0000_0000_FF80_0001, "R6 neg32 sNaN");
        step(1, 1, 1, 1, 1, 64'h7FF0_0000_0000_0000, "R6 neg64 inf kept");
        step(1, 0, 1, 0, 3, 64'h0000_0000_FF80_0000, "R6 abs32 inf kept");
        step(1, 1, 0, 1, 1, 64'h7FF4_0000_0000_00AB, "R7 neg64 NaN payload");
        step(1, 0, 0, 0, 3, 64'h0000_0000_FFC1_2345, "R7 abs32 NaN payload");
        step(1, 1, 0, 2, 1, 64'h1111_2222_3333_4444, "R8 bad pair 2/1");
        step(1, 1, 0, 0, 0, 64'h5555_6666_7777_8888, "R8 bad pair 0/0");
        step(1, 0, 1, 1, 3, 64'h0000_0000_7F80_0001, "R8 bad pair 1/3");
        step(0, 1, 0, 0, 1, 64'hAAAA_BBBB_CCCC_DDDD, "R9 idle hold");
        step(1, 0, 1, 0, 1, 64'h0000_0000_7F80_0001, "R3 copy32 sNaN dnan on");
        step(0, 0, 0, 0, 3, 64'h0, "R9 idle after copy");
        for (int i = 0; i < 24; i++) begin
            step(1, i[0], i[1], {3'b0, i[2]}, (i % 3 == 0) ? 2'd3 : 2'd1,
                 {i[7:0], 24'hF00000 ^ {16'h0, i[7:0]}, 32'h7FA0_0000 ^ i}, "R2 back-to-back");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no finish, expected end of sequence");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule